// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block is the memory-mapped front end of a host bridge's configuration path. The host sees two 4 KiB windows. The index window holds one 32-bit configuration address register. The data window turns each access into a single downstream configuration transaction. When a data-window access arrives, the stored index is combined with the low bits of the access offset to form a conventional configuration address. That address, the access size and the write data are captured in registers, and one request is issued on a simple request/acknowledge port. The host is held off until the response comes back.

The index register is read in one of three layouts, chosen from its own contents:

- **Pass-through:** bit 31 set. The address is passed through with the byte offset merged in.
- **Type-1 style:** bit 0 set. The low three bits are replaced by the offset.
- **One-hot select:** neither bit set. The lowest set bit among bits [31:11] selects the device. A find-first-set stage converts it into a binary device number before the address is built.

A one-hot index with no select bit set produces no downstream traffic. Writes in that case are discarded and reads return all ones.

Top module: `cfgx_translator`

## Requirements
- R1: After reset the index register reads 0x00000000. A full-word write to the index window reads back unchanged.
- R2: Index-window accesses are little-endian. Size code 0 means 1 byte, code 1 means 2 bytes, code 2 means 4 bytes. Writes update only the byte lanes from offset[1:0] upward that lie within the size. Reads return the register shifted right by 8*offset[1:0] and masked to the size. Index-window offset bits [11:2] are ignored.
- R3: Pass-through format (index bit 31 = 1): the downstream address is the index OR offset[1:0].
- R4: Type-1 format (bit 31 = 0, bit 0 = 1): the downstream address is the index with bits [2:0] cleared, OR offset[2:0].
- R5: One-hot format (bits 31 and 0 both 0): the device number is the absolute bit position of the lowest set bit in index[31:11]. The downstream address is {16'h0, device[4:0], index[10:8], index[7:3], offset[2:0]}.
- R6: In the one-hot format with index[31:11] all zero, no downstream request is made. A write is dropped. A read returns 0xFFFFFFFF with host_ready one cycle after the access is presented.
- R7: The size code, the write flag and the write data of a data-window access appear unchanged on the downstream port.
- R8: Exactly one downstream request is outstanding. dn_req and its address, size and data stay stable until dn_ack. host_ready for a data access rises only in the cycle after the acknowledge, and never while dn_req is high.
- R9: A data-window read returns the dn_rdata value that was present with dn_ack.
- R10: host_win = 1 selects the data window. An index-window access completes with host_ready in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_ready | output | 1 | Access complete; read data valid this cycle |
| host_win | input | 1 | 0 = index window, 1 = data window |
| host_off | input | OFF_W | Byte offset within the selected window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| host_wdata | input | 32 | Right-aligned write data |
| host_rdata | output | 32 | Right-aligned read data |
| dn_req | output | 1 | Downstream configuration request, held until dn_ack |
| dn_we | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Translated configuration address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
Data-window accesses are issued with index values in each of the three layouts, so a wrong format choice shows up as a wrong captured address. The one-hot cases use a single select bit, several select bits, and the highest usable bit. These separate lowest-bit from highest-bit selection and expose an off-by-one in the device number. A one-hot index with no select bit checks the suppressed path, for both a read and a write. Byte and half-word index writes at different offsets distinguish correct lane placement from a whole-word overwrite. Acknowledge latency is measured on every access to confirm the one-outstanding handshake.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_DONE = 2'd2
   } seq_t;

   typedef enum logic [1:0] {
      FMT_PASS  = 2'd0,
      FMT_TYPE1 = 2'd1,
      FMT_ONEHOT = 2'd2
   } fmt_t;

   function automatic logic [3:0] lane_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: lane_mask = 4'b0001;
         SZ_HALF: lane_mask = 4'b0011;
         default: lane_mask = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] bit_mask(input logic [1:0] sz);
      logic [3:0] m;
      m = lane_mask(sz);
      for (int b = 0; b < 4; b++) begin
         bit_mask[8*b +: 8] = {8{m[b]}};
      end
   endfunction

endpackage

// File: rtl/cfgx_ffs.sv
module cfgx_ffs #(
   parameter int W      = 21,
   parameter int STYLE  = 0,
   localparam int POS_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [POS_W-1:0] pos
);

   assign found = |vec;

   generate
      if (STYLE == 0) begin : g_scan
         always_comb begin
            pos = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) pos = POS_W'(i);
            end
         end
      end else begin : g_isolate
         logic [W-1:0] low_only;
         assign low_only = vec & (~vec + W'(1));
         always_comb begin
            pos = '0;
            for (int i = 0; i < W; i++) begin
               if (low_only[i]) pos = pos | POS_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
   import cfgx_pkg::*;
#(
   parameter int SEL_LO    = 11,
   parameter int FFS_STYLE = 0,
   localparam int SPAN     = 32 - SEL_LO,
   localparam int POS_W    = (SPAN > 1) ? $clog2(SPAN) : 1
) (
   input  logic [31:0] idx,
   input  logic [2:0]  off,
   output logic [31:0] cfg_addr,
   output logic        hit,
   output fmt_t        fmt
);

   logic             sel_found;
   logic [POS_W-1:0] sel_pos;
   logic [4:0]       dev_num;

   cfgx_ffs #(.W(SPAN), .STYLE(FFS_STYLE)) u_ffs (
      .vec   (idx[31:SEL_LO]),
      .found (sel_found),
      .pos   (sel_pos)
   );

   assign dev_num = 5'(sel_pos) + 5'(SEL_LO);

   always_comb begin
      if (idx[31])     fmt = FMT_PASS;
      else if (idx[0]) fmt = FMT_TYPE1;
      else             fmt = FMT_ONEHOT;
   end

   always_comb begin
      case (fmt)
         FMT_PASS: begin
            cfg_addr = idx | {30'd0, off[1:0]};
            hit      = 1'b1;
         end
         FMT_TYPE1: begin
            cfg_addr = {idx[31:3], off};
            hit      = 1'b1;
         end
         default: begin
            cfg_addr = {16'd0, dev_num, idx[10:8], idx[7:3], off};
            hit      = sel_found;
         end
      endcase
   end

endmodule

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
   import cfgx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  lane,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   output logic [31:0] idx_q,
   output logic [31:0] rdata
);

   logic [3:0]  wr_lanes;
   logic [31:0] wr_shift;

   assign wr_lanes = 4'(lane_mask(size) << lane);
   assign wr_shift = wdata << {lane, 3'b000};

   for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q[8*b +: 8] <= 8'h00;
         end else if (wr_en && wr_lanes[b]) begin
            idx_q[8*b +: 8] <= wr_shift[8*b +: 8];
         end
      end
   end

   assign rdata = (idx_q >> {lane, 3'b000}) & bit_mask(size);

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
   import cfgx_pkg::*;
#(
   parameter int          OFF_W     = 12,
   parameter int          DATA_W    = 32,
   parameter int          SEL_LO    = 11,
   parameter int          FFS_STYLE = 0,
   parameter logic [31:0] MISS_DATA = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   output logic              host_ready,
   input  logic              host_win,
   input  logic [OFF_W-1:0]  host_off,
   input  logic              host_we,
   input  logic [1:0]        host_size,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              dn_req,
   output logic              dn_we,
   output logic [1:0]        dn_size,
   output logic [31:0]       dn_addr,
   output logic [31:0]       dn_wdata,
   input  logic              dn_ack,
   input  logic [31:0]       dn_rdata
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfgx_translator: DATA_W must be 32");
      end
      if (OFF_W < 3) begin : g_bad_off
         $error("cfgx_translator: OFF_W must cover at least three offset bits");
      end
      if (SEL_LO < 11 || SEL_LO > 31) begin : g_bad_sel
         $error("cfgx_translator: SEL_LO must lie in 11..31");
      end
   endgenerate

   seq_t        st_q;
   logic [31:0] idx_q;
   logic [31:0] idx_rdata;
   logic [31:0] xl_addr;
   logic        xl_hit;
   fmt_t        xl_fmt;
   logic [31:0] addr_q;
   logic [31:0] wdata_q;
   logic [31:0] rdata_q;
   logic [1:0]  size_q;
   logic        we_q;
   logic        idx_access;
   logic        data_start;
   logic        unused_bits;

   assign unused_bits = ^{host_off[OFF_W-1:3], xl_fmt};

   assign idx_access = (st_q == ST_IDLE) && host_valid && !host_win;
   assign data_start = (st_q == ST_IDLE) && host_valid && host_win;

   cfgx_index_reg u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (idx_access && host_we),
      .lane  (host_off[1:0]),
      .size  (host_size),
      .wdata (host_wdata),
      .idx_q (idx_q),
      .rdata (idx_rdata)
   );

   cfgx_xlate #(.SEL_LO(SEL_LO), .FFS_STYLE(FFS_STYLE)) u_xlate (
      .idx      (idx_q),
      .off      (host_off[2:0]),
      .cfg_addr (xl_addr),
      .hit      (xl_hit),
      .fmt      (xl_fmt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         size_q  <= SZ_BYTE;
         we_q    <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (data_start) begin
                  addr_q  <= xl_addr;
                  wdata_q <= host_wdata;
                  size_q  <= host_size;
                  we_q    <= host_we;
                  if (xl_hit) begin
                     st_q <= ST_REQ;
                  end else begin
                     rdata_q <= MISS_DATA;
                     st_q    <= ST_DONE;
                  end
               end
            end
            ST_REQ: begin
               if (dn_ack) begin
                  rdata_q <= dn_rdata;
                  st_q    <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign host_ready = (st_q == ST_DONE) || idx_access;
   assign host_rdata = (st_q == ST_DONE) ? rdata_q : idx_rdata;

   assign dn_req   = (st_q == ST_REQ);
   assign dn_we    = we_q;
   assign dn_size  = size_q;
   assign dn_addr  = addr_q;
   assign dn_wdata = wdata_q;

endmodule

// File: rtl/cfgx_translator_chk.sv
module cfgx_translator_chk #(
   parameter int SEL_LO = 11
) (
   input logic        clk,
   input logic        rst_n,
   input logic        host_valid,
   input logic        host_win,
   input logic        host_ready,
   input logic        dn_req,
   input logic        dn_ack,
   input logic        dn_we,
   input logic [1:0]  dn_size,
   input logic [31:0] dn_addr,
   input logic [31:0] dn_wdata,
   input logic [31:0] idx_q
);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr)));

   p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> !host_ready);

   p_attr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_ack) |=> ($stable(dn_we) && $stable(dn_size) && $stable(dn_wdata)));

   p_no_req_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dn_req && host_valid && host_win && !idx_q[0] && (idx_q[31:SEL_LO] == '0))
      |=> !dn_req);

   p_onehot_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !idx_q[31] && !idx_q[0]) |->
      ((dn_addr[31:16] == 16'd0) && (dn_addr[10:3] == idx_q[10:3])));

   p_pass_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && idx_q[31]) |-> (dn_addr[31:2] == idx_q[31:2]));

endmodule

bind cfgx_translator cfgx_translator_chk #(.SEL_LO(SEL_LO)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_valid (host_valid),
   .host_win   (host_win),
   .host_ready (host_ready),
   .dn_req     (dn_req),
   .dn_ack     (dn_ack),
   .dn_we      (dn_we),
   .dn_size    (dn_size),
   .dn_addr    (dn_addr),
   .dn_wdata   (dn_wdata),
   .idx_q      (idx_q)
);

// File: tb/cfgx_translator_bench.sv
`timescale 1ns/1ps
module cfgx_translator_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_ready;
   logic        host_win = 1'b0;
   logic [11:0] host_off = '0;
   logic        host_we = 1'b0;
   logic [1:0]  host_size = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        dn_req;
   logic        dn_we;
   logic [1:0]  dn_size;
   logic [31:0] dn_addr;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int nvec = 0;
   int nbad = 0;
   bit finished = 0;
   logic [66:0] exp_q[$];

   always #5 clk = ~clk;

   cfgx_translator u_cfgx_translator (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_ready(host_ready), .host_win(host_win),
      .host_off(host_off), .host_we(host_we), .host_size(host_size),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr),
      .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   function automatic logic [31:0] resp_of(input logic [31:0] a);
      return ~a ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] szmask(input logic [1:0] s);
      return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
   endfunction

   // expected translation; bit 32 flags a miss
   function automatic logic [32:0] model_xl(input logic [31:0] idx, input logic [2:0] off);
      if (idx[31]) return {1'b0, idx | {30'd0, off[1:0]}};
      if (idx[0])  return {1'b0, idx[31:3], off};
      for (int i = 11; i < 32; i++) begin
         if (idx[i]) return {1'b0, 16'd0, 5'(i), idx[10:8], idx[7:3], off};
      end
      return {1'b1, 32'd0};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic host_op(input logic win, input logic [11:0] off, input logic we,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
      @(negedge clk);
      host_valid = 1'b1; host_win = win; host_off = off;
      host_we = we; host_size = sz; host_wdata = wd;
      lat = 0;
      forever begin
         #2;
         if (host_ready) begin
            rd = host_rdata;
            break;
         end
         @(negedge clk);
         lat++;
      end
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   // downstream responder and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (dn_req) begin
            nvec++;
            if (exp_q.size() == 0) begin
               nbad++;
               $display("FAIL R6 unexpected request: actual %h expected none", dn_addr);
            end else begin
               logic [66:0] e;
               e = exp_q.pop_front();
               if ({dn_we, dn_size, dn_addr, dn_wdata} !== e) begin
                  nbad++;
                  $display("FAIL R3/R4/R5/R7 request: actual %h expected %h",
                           {dn_we, dn_size, dn_addr, dn_wdata}, e);
               end
            end
            repeat (2) @(negedge clk);
            dn_rdata = resp_of(dn_addr);
            dn_ack = 1'b1;
            @(negedge clk);
            dn_ack = 1'b0;
         end
      end
   end

   logic [31:0] idx_model = '0;

   task automatic idx_write(input logic [11:0] off, input logic [1:0] sz, input logic [31:0] wd);
      logic [31:0] rd;
      int lat;
      logic [31:0] m;
      m = szmask(sz) << {off[1:0], 3'b000};
      idx_model = (idx_model & ~m) | ((wd << {off[1:0], 3'b000}) & m);
      host_op(1'b0, off, 1'b1, sz, wd, rd, lat);
      check("R10 index write latency", 32'(lat), 32'd0);
   endtask

   task automatic idx_read(input string tag, input logic [11:0] off, input logic [1:0] sz);
      logic [31:0] rd;
      int lat;
      host_op(1'b0, off, 1'b0, sz, 32'd0, rd, lat);
      check(tag, rd, (idx_model >> {off[1:0], 3'b000}) & szmask(sz));
   endtask

   task automatic data_op(input string tag, input logic [11:0] off, input logic we,
                          input logic [1:0] sz, input logic [31:0] wd);
      logic [32:0] x;
      logic [31:0] rd;
      int lat;
      x = model_xl(idx_model, off[2:0]);
      if (!x[32]) exp_q.push_back({we, sz, x[31:0], wd});
      host_op(1'b1, off, we, sz, wd, rd, lat);
      if (x[32]) begin
         check({tag, " R6 miss latency"}, 32'(lat), 32'd1);
         if (!we) check({tag, " R6 miss data"}, rd, 32'hFFFF_FFFF);
      end else begin
         check({tag, " R8 latency"}, 32'(lat), 32'd4);
         if (!we) check({tag, " R9 read data"}, rd, resp_of(x[31:0]));
      end
      check({tag, " R8 queue drained"}, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      idx_read("R1 reset value", 12'h000, 2'd2);
      idx_write(12'h000, 2'd2, 32'h8000_0A14);
      idx_read("R1 word readback", 12'h000, 2'd2);
      idx_read("R10 index alias offset", 12'h7F4, 2'd2);

      data_op("R3 byte read", 12'h003, 1'b0, 2'd0, 32'd0);
      data_op("R3 half write", 12'h002, 1'b1, 2'd1, 32'h0000_BEEF);

      idx_write(12'h000, 2'd2, 32'h0012_3405);
      data_op("R4 read", 12'h006, 1'b0, 2'd2, 32'd0);
      data_op("R4 R7 word write", 12'h007, 1'b1, 2'd2, 32'h1122_3344);

      idx_write(12'h000, 2'd2, 32'h0000_0D3C);
      data_op("R5 single bit", 12'h001, 1'b0, 2'd1, 32'd0);
      idx_write(12'h000, 2'd2, 32'h0210_0104);
      data_op("R5 lowest of several", 12'h005, 1'b0, 2'd0, 32'd0);
      idx_write(12'h000, 2'd2, 32'h4000_07F8);
      data_op("R5 R7 highest bit write", 12'h000, 1'b1, 2'd0, 32'h0000_005A);

      idx_write(12'h000, 2'd2, 32'h0000_0700);
      data_op("R6 read", 12'h004, 1'b0, 2'd2, 32'd0);
      data_op("R6 write", 12'h004, 1'b1, 2'd2, 32'hDEAD_BEEF);

      idx_write(12'h000, 2'd2, 32'h1122_3344);
      idx_write(12'h002, 2'd0, 32'h0000_00AB);
      idx_read("R2 byte lane merge", 12'h000, 2'd2);
      idx_read("R2 byte read", 12'h002, 2'd0);
      idx_write(12'h001, 2'd1, 32'h0000_C0DE);
      idx_read("R2 half lane merge", 12'h000, 2'd2);
      idx_read("R2 half read", 12'h001, 2'd1);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule